// File: doc/BRIEF.md
# Stateful implication row engine

This block is a cycle-level digital model of one row of resistive stateful cells that compute in place. The row holds a parameterised number of single-bit cells. On each clock edge at most one micro-operation is carried out on the row: clearing a cell, computing an implication between two cells, loading the whole row in parallel, or refreshing the row's drift state. The row contents are always visible on a parallel read port.

An implication step is destructive. It reads a source cell p and a destination cell q and writes (NOT p) OR q back into q. A cell can therefore only be driven towards 1 by this step. When p is 1 and q is 0 the cell stays at 0, but it is weakened by one drift unit. Each cell counts its own weakening events. Three of them are tolerated. A fourth, if no refresh has come first, corrupts the cell to 1. The block raises a refresh request as long as any cell has used up its budget. A controller issues the refresh before it lets more implications hit that cell.

A control sequencer builds any Boolean function from sequences of clears and implications on the row. Illegal implications are refused and reported through an error flag. An implication is illegal when its source and destination are the same cell, or when either index lies outside the row.

Top module: `imply_row_engine`

## Requirements
- R1: A synchronous active-high reset sets every cell to 0, clears every drift counter, and drives refresh_req and op_err low from the first edge on which reset is sampled.
- R2: LOAD (op_code 2'b10) with op_valid high writes load_data[i] into cell i for every i at the next edge and clears every drift counter.
- R3: FALSE (op_code 2'b00) forces cell dst_idx to 0 and clears its drift counter at the next edge. All other cells keep their values.
- R4: IMPLY (op_code 2'b01) replaces cell dst_idx with (NOT cell src_idx) OR cell dst_idx at the next edge. The source cell and all other cells are unchanged.
- R5: An IMPLY with source 1 and destination 0 leaves the destination at 0 and increments its drift counter. refresh_req is high whenever any cell's counter equals 3.
- R6: An IMPLY with source 1 on a destination at 0 whose counter is already 3 flips that destination to 1 and clears its counter.
- R7: REFRESH (op_code 2'b11) clears every drift counter and keeps every cell value.
- R8: An IMPLY that sets its destination from 0 to 1 clears that cell's drift counter.
- R9: An IMPLY is illegal when src_idx equals dst_idx or when either index is not below CELLS. An illegal IMPLY changes no cell and no counter. op_err is high for exactly the cycle after an illegal IMPLY and low after any other cycle.
- R10: With op_valid low, no cell and no counter changes. At most one operation takes effect per clock edge, and all outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 2 | 00 FALSE, 01 IMPLY, 10 LOAD, 11 REFRESH |
| src_idx | input | $clog2(CELLS) | Source cell p for IMPLY |
| dst_idx | input | $clog2(CELLS) | Destination cell q for IMPLY and FALSE |
| load_data | input | CELLS | Parallel write data for LOAD |
| row_q | output | CELLS | Current cell values, bit i is cell i |
| refresh_req | output | 1 | Some cell has reached its drift budget |
| op_err | output | 1 | Previous cycle carried an illegal IMPLY |

## Verification
The hardest state to reach is the corrupting fourth weakening. Getting there takes three back-to-back source-1 implications onto the same 0 cell with no intervening refresh, clear or set, and then a fourth. The stimulus table builds this run up on one cell and watches refresh_req rise on the third step and fall again on the flip. It then rebuilds the same run and ends it twice more: once with REFRESH, and once with a setting implication, which shows that each path clears the budget. Reset during a saturated counter and a same-cell implication are driven as directed cases.

// File: rtl/imply_row_pkg.sv
package imply_row_pkg;
   typedef enum logic [1:0] {
      OP_FALSE   = 2'b00,
      OP_IMPLY   = 2'b01,
      OP_LOAD    = 2'b10,
      OP_REFRESH = 2'b11
   } row_op_e;
endpackage

// File: rtl/imply_cell.sv
module imply_cell #(
   parameter int DRIFT_LIMIT = 3,
   localparam int DRIFT_W = $clog2(DRIFT_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic load_en,
   input  logic load_bit,
   input  logic refresh_en,
   input  logic false_en,
   input  logic imply_en,
   input  logic p_bit,
   output logic q_bit,
   output logic drift_full
);
   localparam logic [DRIFT_W-1:0] LIMIT = DRIFT_W'(DRIFT_LIMIT);

   logic               q_q;
   logic [DRIFT_W-1:0] drift_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_q     <= 1'b0;
         drift_q <= '0;
      end else if (load_en) begin
         q_q     <= load_bit;
         drift_q <= '0;
      end else if (refresh_en) begin
         drift_q <= '0;
      end else if (false_en) begin
         q_q     <= 1'b0;
         drift_q <= '0;
      end else if (imply_en && !q_q) begin
         if (!p_bit) begin
            q_q     <= 1'b1;
            drift_q <= '0;
         end else if (drift_q == LIMIT) begin
            q_q     <= 1'b1;
            drift_q <= '0;
         end else begin
            drift_q <= drift_q + 1'b1;
         end
      end
   end

   assign q_bit      = q_q;
   assign drift_full = (drift_q == LIMIT);

   // R4
   keep_one_chk: assert property (@(posedge clk) disable iff (rst)
      (imply_en && q_q && !load_en && !false_en) |=> q_q);
   // R5
   weaken_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (imply_en && p_bit && !q_q && !drift_full && !load_en && !refresh_en && !false_en)
      |=> (!q_q && drift_q == $past(drift_q) + 1'b1));
endmodule

// File: rtl/imply_row_ctrl.sv
module imply_row_ctrl
   import imply_row_pkg::*;
#(
   parameter int CELLS = 8,
   localparam int IDX_W = $clog2(CELLS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_valid,
   input  row_op_e          op_code,
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic [CELLS-1:0] row_val,
   output logic             load_en,
   output logic             refresh_en,
   output logic [CELLS-1:0] false_vec,
   output logic [CELLS-1:0] imply_vec,
   output logic             p_bit,
   output logic             op_err
);
   logic src_ok, dst_ok, imply_req, imply_legal, false_legal, err_q;

   if (CELLS == (1 << IDX_W)) begin : g_full_range
      assign src_ok = 1'b1;
      assign dst_ok = 1'b1;
   end else begin : g_part_range
      assign src_ok = (32'(src_idx) < CELLS);
      assign dst_ok = (32'(dst_idx) < CELLS);
   end

   assign imply_req   = op_valid && (op_code == OP_IMPLY);
   assign imply_legal = imply_req && src_ok && dst_ok && (src_idx != dst_idx);
   assign false_legal = op_valid && (op_code == OP_FALSE) && dst_ok;
   assign load_en     = op_valid && (op_code == OP_LOAD);
   assign refresh_en  = op_valid && (op_code == OP_REFRESH);
   assign p_bit       = src_ok ? row_val[src_idx] : 1'b0;

   for (genvar i = 0; i < CELLS; i++) begin : g_sel
      assign false_vec[i] = false_legal && (32'(dst_idx) == i);
      assign imply_vec[i] = imply_legal && (32'(dst_idx) == i);
   end

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= imply_req && !imply_legal;
   end
   assign op_err = err_q;

   // R9
   single_dst_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(imply_vec | false_vec));
endmodule

// File: rtl/imply_row_engine.sv
module imply_row_engine
   import imply_row_pkg::*;
#(
   parameter int CELLS       = 8,
   parameter int DRIFT_LIMIT = 3,
   localparam int IDX_W = $clog2(CELLS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_valid,
   input  logic [1:0]       op_code,
   input  logic [IDX_W-1:0] src_idx,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic [CELLS-1:0] load_data,
   output logic [CELLS-1:0] row_q,
   output logic             refresh_req,
   output logic             op_err
);
   if (CELLS < 2) begin : g_bad_cells
      $error("imply_row_engine: CELLS must be at least 2");
   end
   if (DRIFT_LIMIT < 1) begin : g_bad_limit
      $error("imply_row_engine: DRIFT_LIMIT must be at least 1");
   end

   logic             load_en, refresh_en, p_bit;
   logic [CELLS-1:0] false_vec, imply_vec, full_vec;

   imply_row_ctrl #(.CELLS(CELLS)) ctrl_i (
      .clk       (clk),
      .rst       (rst),
      .op_valid  (op_valid),
      .op_code   (row_op_e'(op_code)),
      .src_idx   (src_idx),
      .dst_idx   (dst_idx),
      .row_val   (row_q),
      .load_en   (load_en),
      .refresh_en(refresh_en),
      .false_vec (false_vec),
      .imply_vec (imply_vec),
      .p_bit     (p_bit),
      .op_err    (op_err)
   );

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      imply_cell #(.DRIFT_LIMIT(DRIFT_LIMIT)) cell_i (
         .clk       (clk),
         .rst       (rst),
         .load_en   (load_en),
         .load_bit  (load_data[i]),
         .refresh_en(refresh_en),
         .false_en  (false_vec[i]),
         .imply_en  (imply_vec[i]),
         .p_bit     (p_bit),
         .q_bit     (row_q[i]),
         .drift_full(full_vec[i])
      );
   end

   assign refresh_req = |full_vec;

   // R9
   err_no_change_chk: assert property (@(posedge clk) disable iff (rst)
      op_err |-> $stable(row_q));
   // R7
   refresh_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == 2'b11) |=> (!refresh_req && $stable(row_q)));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(row_q));
   // R2
   load_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == 2'b10) |=> (row_q == $past(load_data) && !refresh_req));
endmodule

// File: tb/imply_row_engine_tb_top.sv
module imply_row_engine_tb_top;
   localparam int CELLS = 8;
   localparam int NV    = 19;

   logic       clk = 1'b0;
   logic       rst, op_valid;
   logic [1:0] op_code;
   logic [2:0] src_idx, dst_idx;
   logic [7:0] load_data, row_q;
   logic       refresh_req, op_err;
   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   imply_row_engine #(.CELLS(CELLS), .DRIFT_LIMIT(3)) dut_i (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
      .src_idx(src_idx), .dst_idx(dst_idx), .load_data(load_data),
      .row_q(row_q), .refresh_req(refresh_req), .op_err(op_err));

   // {op_code, src, dst, load_data, exp_row, exp_req, exp_err}
   localparam logic [25:0] VEC [NV] = '{
      {2'b10, 3'd0, 3'd0, 8'hA5, 8'hA5, 1'b0, 1'b0},  // R2 load
      {2'b01, 3'd1, 3'd3, 8'h00, 8'hAD, 1'b0, 1'b0},  // R4 p0 q0 sets
      {2'b01, 3'd0, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R5 drift 1
      {2'b01, 3'd0, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R5 drift 2
      {2'b01, 3'd0, 3'd1, 8'h00, 8'hAD, 1'b1, 1'b0},  // R5 drift 3 request
      {2'b01, 3'd1, 3'd2, 8'h00, 8'hAD, 1'b1, 1'b0},  // R4 p0 q1 holds
      {2'b01, 3'd0, 3'd1, 8'h00, 8'hAF, 1'b0, 1'b0},  // R6 fourth flips
      {2'b00, 3'd0, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R3 false
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R5
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R5
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b1, 1'b0},  // R5
      {2'b11, 3'd0, 3'd0, 8'h00, 8'hAD, 1'b0, 1'b0},  // R7 refresh
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R7 counter restarted
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b0, 1'b0},  // R5
      {2'b01, 3'd5, 3'd1, 8'h00, 8'hAD, 1'b1, 1'b0},  // R5
      {2'b01, 3'd4, 3'd1, 8'h00, 8'hAF, 1'b0, 1'b0},  // R8 set clears drift
      {2'b01, 3'd3, 3'd3, 8'h00, 8'hAF, 1'b0, 1'b1},  // R9 same cell
      {2'b00, 3'd0, 3'd7, 8'h00, 8'h2F, 1'b0, 1'b0},  // R3 R9 err drops
      {2'b01, 3'd7, 3'd6, 8'h00, 8'h6F, 1'b0, 1'b0}   // R4 src unchanged
   };

   task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] c, input logic [2:0] s,
                       input logic [2:0] d, input logic [7:0] ld);
      @(negedge clk);
      op_valid = v; op_code = c; src_idx = s; dst_idx = d; load_data = ld;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; op_valid = 1'b0; op_code = 2'b00;
      src_idx = '0; dst_idx = '0; load_data = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset row", row_q, 8'h00);
      check("R1 reset flags", {6'b0, refresh_req, op_err}, 8'h00);
      @(negedge clk) rst = 1'b0;

      step(1'b0, 2'b10, 3'd0, 3'd0, 8'hFF);
      check("R10 idle load ignored", row_q, 8'h00);

      for (int k = 0; k < NV; k++) begin
         step(1'b1, VEC[k][25:24], VEC[k][23:21], VEC[k][20:18], VEC[k][17:10]);
         check($sformatf("table %0d row", k), row_q, VEC[k][9:2]);
         check($sformatf("table %0d req/err", k), {6'b0, refresh_req, op_err},
               {6'b0, VEC[k][1], VEC[k][0]});
      end

      // R10 idle cycle keeps row and drops op_err
      step(1'b0, 2'b01, 3'd0, 3'd0, 8'h00);
      check("R10 idle hold", row_q, 8'h6F);

      // R1 reset while a counter is saturated
      step(1'b1, 2'b10, 3'd0, 3'd0, 8'h01);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      check("R5 saturated request", {7'b0, refresh_req}, 8'h01);
      @(negedge clk) rst = 1'b1;
      @(posedge clk);
      #1;
      check("R1 reset clears request", {6'b0, refresh_req, op_err}, 8'h00);
      check("R1 reset clears row", row_q, 8'h00);
      @(negedge clk) rst = 1'b0;

      // R9 illegal op leaves weakened counter untouched
      step(1'b1, 2'b10, 3'd0, 3'd0, 8'h01);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      step(1'b1, 2'b01, 3'd1, 3'd1, 8'h00);
      check("R9 err flag", {7'b0, op_err}, 8'h01);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      step(1'b1, 2'b01, 3'd0, 3'd1, 8'h00);
      check("R9 counter unchanged by illegal op", {7'b0, refresh_req}, 8'h01);
      check("R9 row unchanged", row_q, 8'h01);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule